// File: doc/BRIEF.md
# SPI Master with Timed Chip Select

This block is a single-target SPI master for a core that feeds it through two small FIFOs. Software loads transmit words, raises a transfer-active bit, and the engine drops chip select, waits a fixed number of core cycles, then shifts words out in mode 0 (clock idles low, data changes on the falling edge, sampled on the rising edge), most significant bit first. Each received word is pushed into the receive FIFO. Words are 8 or 9 bits; the length is set while the bus is idle.

Chip-select timing is the block's main guarantee. A programmable number of core cycles always separates the fall of chip select from the first data bit, and another from the last falling clock edge to the rise of chip select. When the transmit FIFO runs dry while the transfer bit is still high, chip select stays low with the clock idle until more data arrives. Once the transfer bit is low and the transmit FIFO has drained, the transaction closes and a done flag is raised. The interrupt line requests service whenever the FIFOs need attention. Because the transmit FIFO starts empty, the request fires in the same cycle the transfer bit goes high.

Top module: `spi_cs_master`

## Requirements
- R1: After reset: cs_n_o=1, sclk_o=0, mosi_o=0, irq_o=0, done_o=0, tx_empty_o=1, rx_empty_o=1, word_len9_o=0 (8-bit words).
- R2: cs_n_o falls in the cycle after active_i is seen high while idle. The first data bit is never presented sooner than CS_LEAD (default 3) cycles after that fall. If data is waiting, the first SCLK rise comes exactly CS_LEAD+1+H cycles after the fall, where H is the half period of R7.
- R3: cs_n_o rises no sooner than CS_LAG (default 1) cycle after the final falling SCLK edge. If active_i is already low when the last word ends, the rise comes exactly CS_LAG+1 cycles after that edge.
- R4: A write with cfg_we_i while cs_n_o=1 takes cfg_len_i=8 (word_len9_o=0) or cfg_len_i=9 (word_len9_o=1). Any other value, or any write during a transaction, leaves word_len9_o unchanged.
- R5: Mode 0, MSB first. SCLK stays low while cs_n_o=1, and MOSI holds steady while SCLK is high. An 8-bit word sends bits 7..0 of the FIFO entry; a 9-bit word sends bits 8..0.
- R6: MISO is sampled on each rising SCLK edge. Each completed word is pushed into the receive FIFO, MSB first. In 8-bit mode bit 8 of rx_data_o is 0.
- R7: SCLK high and low halves are each H=max(div_i,1) core cycles, giving a period of 2H within a word.
- R8: irq_o = done_o OR (active_i AND (receive FIFO not empty OR transmit FIFO holds at most DEPTH/2 entries)). Raising active_i with an empty transmit FIFO asserts irq_o in that same cycle.
- R9: The transmit FIFO takes DEPTH (16) back-to-back pushes and then reports tx_full_o. A push while full is dropped. rx_data_o shows the oldest entry, and rx_pop_i removes it.
- R10: While active_i is high and the transmit FIFO is empty, cs_n_o stays low and SCLK stays idle. Shifting resumes when a word is pushed.
- R11: When active_i is low and the transmit FIFO is empty at a word boundary, the transaction ends. done_o rises together with cs_n_o and clears when the next transaction starts.
- R12: No word starts while the receive FIFO is full. The engine waits with chip select low until an entry is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| active_i | input | 1 | Transfer-active bit |
| cfg_we_i | input | 1 | Word-length write strobe |
| cfg_len_i | input | 4 | Requested word length (8 or 9) |
| div_i | input | DIV_W | SCLK half period in core cycles (0 acts as 1) |
| tx_push_i | input | 1 | Push tx_data_i into the transmit FIFO |
| tx_data_i | input | 9 | Transmit word |
| rx_pop_i | input | 1 | Pop the oldest receive entry |
| rx_data_o | output | 9 | Oldest receive entry |
| tx_full_o | output | 1 | Transmit FIFO full |
| tx_empty_o | output | 1 | Transmit FIFO empty |
| rx_full_o | output | 1 | Receive FIFO full |
| rx_empty_o | output | 1 | Receive FIFO empty |
| done_o | output | 1 | Transaction finished |
| word_len9_o | output | 1 | Current word length is 9 bits |
| irq_o | output | 1 | Service request |
| sclk_o | output | 1 | SPI clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | 1 | Active-low chip select |

## Verification
The bound checker watches the chip-select margins on every cycle. It also confirms that SCLK is idle whenever chip select is high, that MOSI holds steady across each high half, that the word length is frozen during a transaction, that done only appears with chip select high, and that the service request fires on a start with an empty FIFO. Other properties need a scenario to show them: exact bit order and data integrity in both word lengths, the clock period, the FIFO fill threshold of the interrupt, the stall on a full receive FIFO, and the drop of a push into a full transmit FIFO. The bench drives these with a slave model and compares against expected queues.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;
  localparam int WORD_W = 9;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_READY,
    ST_SHIFT,
    ST_LAG
  } eng_state_t;
endpackage

// File: rtl/spi_cs_fifo.sv
module spi_cs_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push_i,
  input  logic [W-1:0]             data_i,
  input  logic                     pop_i,
  output logic [W-1:0]             data_o,
  output logic                     full_o,
  output logic                     empty_o,
  output logic [$clog2(DEPTH):0]   count_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr, wptr_n, rptr_n;
  logic [CW-1:0] cnt, cnt_n;
  logic          wr_ok, rd_ok;

  always_comb begin
    wr_ok  = push_i && (cnt != CW'(DEPTH));
    rd_ok  = pop_i && (cnt != '0);
    wptr_n = wptr;
    rptr_n = rptr;
    cnt_n  = cnt;
    if (wr_ok) wptr_n = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
    if (rd_ok) rptr_n = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
    if (wr_ok && !rd_ok) cnt_n = cnt + 1'b1;
    else if (rd_ok && !wr_ok) cnt_n = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      wptr <= wptr_n;
      rptr <= rptr_n;
      cnt  <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= data_i;
  end

  assign data_o  = mem[rptr];
  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign count_o = cnt;
endmodule

// File: rtl/spi_cs_engine.sv
module spi_cs_engine
  import spi_cs_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int CS_LEAD = 3,
  parameter int CS_LAG  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic              len9_i,
  input  logic [DIV_W-1:0]  half_i,
  input  logic              tx_empty_i,
  input  logic [WORD_W-1:0] tx_data_i,
  output logic              tx_pop_o,
  input  logic              rx_full_i,
  output logic              rx_push_o,
  output logic [WORD_W-1:0] rx_data_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_n_o,
  output logic              done_o
);
  localparam int TW = $clog2(CS_LEAD + CS_LAG + 1) + 1;

  eng_state_t        st, st_n;
  logic [TW-1:0]     cnt, cnt_n;
  logic [DIV_W-1:0]  hc, hc_n, half_eff;
  logic              ph, ph_n;
  logic [3:0]        bitc, bitc_n;
  logic [WORD_W-1:0] tsh, tsh_n, rsh, rsh_n;
  logic              done, done_n;
  logic              last_bit;

  always_comb begin
    half_eff  = (half_i == '0) ? DIV_W'(1) : half_i;
    last_bit  = (bitc == (len9_i ? 4'd8 : 4'd7));
    st_n      = st;
    cnt_n     = cnt;
    hc_n      = hc;
    ph_n      = ph;
    bitc_n    = bitc;
    tsh_n     = tsh;
    rsh_n     = rsh;
    done_n    = done;
    tx_pop_o  = 1'b0;
    rx_push_o = 1'b0;
    case (st)
      ST_IDLE: begin
        if (active_i) begin
          st_n   = ST_LEAD;
          cnt_n  = '0;
          done_n = 1'b0;
        end
      end
      ST_LEAD: begin
        if (cnt == TW'(CS_LEAD - 1)) st_n = ST_READY;
        else cnt_n = cnt + 1'b1;
      end
      ST_READY: begin
        if (!tx_empty_i && !rx_full_i) begin
          tx_pop_o = 1'b1;
          tsh_n    = tx_data_i;
          st_n     = ST_SHIFT;
          hc_n     = '0;
          ph_n     = 1'b0;
          bitc_n   = '0;
        end else if (!active_i && tx_empty_i) begin
          st_n  = ST_LAG;
          cnt_n = '0;
        end
      end
      ST_SHIFT: begin
        if (hc == half_eff - 1'b1) begin
          hc_n = '0;
          if (!ph) begin
            ph_n  = 1'b1;
            rsh_n = {rsh[WORD_W-2:0], miso_i};
          end else begin
            ph_n = 1'b0;
            if (last_bit) begin
              rx_push_o = 1'b1;
              st_n      = ST_READY;
            end else begin
              bitc_n = bitc + 1'b1;
              tsh_n  = {tsh[WORD_W-2:0], 1'b0};
            end
          end
        end else begin
          hc_n = hc + 1'b1;
        end
      end
      ST_LAG: begin
        if (cnt == TW'(CS_LAG - 1)) begin
          st_n   = ST_IDLE;
          done_n = 1'b1;
        end else begin
          cnt_n = cnt + 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      hc   <= '0;
      ph   <= 1'b0;
      bitc <= '0;
      tsh  <= '0;
      rsh  <= '0;
      done <= 1'b0;
    end else begin
      st   <= st_n;
      cnt  <= cnt_n;
      hc   <= hc_n;
      ph   <= ph_n;
      bitc <= bitc_n;
      tsh  <= tsh_n;
      rsh  <= rsh_n;
      done <= done_n;
    end
  end

  assign cs_n_o    = (st == ST_IDLE);
  assign sclk_o    = (st == ST_SHIFT) && ph;
  assign mosi_o    = (st == ST_SHIFT) && (len9_i ? tsh[8] : tsh[7]);
  assign rx_data_o = len9_i ? rsh : {1'b0, rsh[7:0]};
  assign done_o    = done;
endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master
  import spi_cs_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int DIV_W   = 8,
  parameter int CS_LEAD = 3,
  parameter int CS_LAG  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active_i,
  input  logic              cfg_we_i,
  input  logic [3:0]        cfg_len_i,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              tx_push_i,
  input  logic [8:0]        tx_data_i,
  input  logic              rx_pop_i,
  output logic [8:0]        rx_data_o,
  output logic              tx_full_o,
  output logic              tx_empty_o,
  output logic              rx_full_o,
  output logic              rx_empty_o,
  output logic              done_o,
  output logic              word_len9_o,
  output logic              irq_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic              cs_n_o
);
  localparam int CW   = $clog2(DEPTH) + 1;
  localparam int HALF = DEPTH / 2;

  logic              len9, len9_n;
  logic [CW-1:0]     tx_cnt, rx_cnt;
  logic [WORD_W-1:0] eng_tx_data, eng_rx_data;
  logic              eng_tx_pop, eng_rx_push;

  always_comb begin
    len9_n = len9;
    if (cfg_we_i && cs_n_o) begin
      if (cfg_len_i == 4'd8) len9_n = 1'b0;
      else if (cfg_len_i == 4'd9) len9_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len9 <= 1'b0;
    else        len9 <= len9_n;
  end

  spi_cs_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_i(tx_push_i), .data_i(tx_data_i),
    .pop_i(eng_tx_pop), .data_o(eng_tx_data),
    .full_o(tx_full_o), .empty_o(tx_empty_o), .count_o(tx_cnt)
  );

  spi_cs_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_i(eng_rx_push), .data_i(eng_rx_data),
    .pop_i(rx_pop_i), .data_o(rx_data_o),
    .full_o(rx_full_o), .empty_o(rx_empty_o), .count_o(rx_cnt)
  );

  spi_cs_engine #(.DIV_W(DIV_W), .CS_LEAD(CS_LEAD), .CS_LAG(CS_LAG)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .active_i(active_i), .len9_i(len9), .half_i(div_i),
    .tx_empty_i(tx_empty_o), .tx_data_i(eng_tx_data), .tx_pop_o(eng_tx_pop),
    .rx_full_i(rx_full_o), .rx_push_o(eng_rx_push), .rx_data_o(eng_rx_data),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i),
    .cs_n_o(cs_n_o), .done_o(done_o)
  );

  assign word_len9_o = len9;
  assign irq_o       = done_o || (active_i && ((rx_cnt != '0) || (tx_cnt <= CW'(HALF))));
endmodule

// File: rtl/spi_cs_master_chk.sv
module spi_cs_master_chk #(
  parameter int CS_LEAD = 3,
  parameter int CS_LAG  = 1
) (
  input logic clk,
  input logic rst_n,
  input logic cs_n_o,
  input logic sclk_o,
  input logic mosi_o,
  input logic active_i,
  input logic tx_empty_o,
  input logic irq_o,
  input logic word_len9_o,
  input logic done_o
);
  localparam int SW = $clog2(CS_LEAD + CS_LAG + 2) + 1;

  logic [SW-1:0] since_cs, since_fall;
  logic          sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_cs   <= '0;
      since_fall <= '1;
      sclk_q     <= 1'b0;
    end else begin
      sclk_q <= sclk_o;
      if (cs_n_o) since_cs <= '0;
      else if (since_cs != '1) since_cs <= since_cs + 1'b1;
      if (sclk_q && !sclk_o) since_fall <= '0;
      else if (since_fall != '1) since_fall <= since_fall + 1'b1;
    end
  end

  AST_CS_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk_o) |-> (since_cs >= SW'(CS_LEAD)));                        // R2
  AST_CS_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> (since_fall >= SW'(CS_LAG)));                       // R3
  AST_LEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && $past(!cs_n_o)) |-> $stable(word_len9_o));                // R4
  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);                                                  // R5
  AST_MOSI_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));                       // R5
  AST_IRQ_START: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(active_i) && tx_empty_o) |-> irq_o);                           // R8
  AST_DONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> cs_n_o);                                                   // R11
endmodule

bind spi_cs_master spi_cs_master_chk #(.CS_LEAD(CS_LEAD), .CS_LAG(CS_LAG)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .mosi_o(mosi_o),
  .active_i(active_i), .tx_empty_o(tx_empty_o), .irq_o(irq_o),
  .word_len9_o(word_len9_o), .done_o(done_o)
);

// File: tb/spi_cs_master_bench.sv
module spi_cs_master_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int DIV_W      = 8;
  localparam int CS_LEAD    = 3;
  localparam int CS_LAG     = 1;

  logic clk = 1'b0;
  logic rst_n;
  logic active_i, cfg_we_i, tx_push_i, rx_pop_i;
  logic [3:0] cfg_len_i;
  logic [DIV_W-1:0] div_i;
  logic [8:0] tx_data_i, rx_data_o;
  logic tx_full_o, tx_empty_o, rx_full_o, rx_empty_o, done_o, word_len9_o, irq_o;
  logic sclk_o, mosi_o, cs_n_o;
  logic miso_i = 1'b0;

  spi_cs_master #(.DEPTH(DEPTH), .DIV_W(DIV_W), .CS_LEAD(CS_LEAD), .CS_LAG(CS_LAG)) u_spi_cs_master (
    .clk(clk), .rst_n(rst_n), .active_i(active_i), .cfg_we_i(cfg_we_i), .cfg_len_i(cfg_len_i),
    .div_i(div_i), .tx_push_i(tx_push_i), .tx_data_i(tx_data_i), .rx_pop_i(rx_pop_i),
    .rx_data_o(rx_data_o), .tx_full_o(tx_full_o), .tx_empty_o(tx_empty_o), .rx_full_o(rx_full_o),
    .rx_empty_o(rx_empty_o), .done_o(done_o), .word_len9_o(word_len9_o), .irq_o(irq_o),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i), .cs_n_o(cs_n_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Bench-side model state
  int cyc = 0, t_csf = 0, t_rise = 0, t_fall = 0, n_rise = 0;
  int half = 1, blen = 8, cap_cnt = 0, s_bit = 0;
  bit p_cs = 1'b1, p_sclk = 1'b0, want_first = 1'b0, lead_exact = 1'b1, lag_exact = 1'b1;
  logic [8:0] bmask = 9'h0FF, cap = '0, s_sh = '0, s_word = '0;
  logic [8:0] exp_tx[$];
  logic [8:0] exp_rx[$];

  function automatic logic [8:0] mask_of(input bit l9);
    return l9 ? 9'h1FF : 9'h0FF;
  endfunction

  // Monitor and slave model, all evaluated away from the rising clock edge
  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (p_cs && !cs_n_o) begin
        t_csf = cyc; want_first = 1'b1;
        s_word = 9'($urandom); s_sh = s_word; s_bit = 0; cap_cnt = 0;
        miso_i = s_sh[blen-1];
      end
      if (!p_sclk && sclk_o) begin
        n_rise++;
        if (want_first) begin
          if (lead_exact) check(cyc - t_csf == CS_LEAD + 1 + half, "R2 CS lead to first SCLK", cyc - t_csf, CS_LEAD + 1 + half);
          else check(cyc - t_csf >= CS_LEAD + 1 + half, "R2 CS lead minimum", cyc - t_csf, CS_LEAD + 1 + half);
          want_first = 1'b0;
        end else if (cap_cnt != 0) begin
          check(cyc - t_rise == 2 * half, "R7 SCLK period", cyc - t_rise, 2 * half);
        end
        t_rise = cyc;
        cap = {cap[7:0], mosi_o};
        cap_cnt++;
        if (cap_cnt == blen) begin
          cap_cnt = 0;
          if (exp_tx.size() == 0) check(1'b0, "R5 unexpected MOSI word (R9 drop)", int'(cap & bmask), -1);
          else begin
            logic [8:0] e;
            e = exp_tx.pop_front();
            check((cap & bmask) == (e & bmask), "R5 MOSI word", int'(cap & bmask), int'(e & bmask));
          end
        end
      end
      if (p_sclk && !sclk_o) begin
        check(cyc - t_rise == half, "R7 SCLK high half", cyc - t_rise, half);
        t_fall = cyc;
        s_bit++;
        if (s_bit == blen) begin
          exp_rx.push_back(s_word & bmask);
          s_word = 9'($urandom); s_sh = s_word; s_bit = 0;
        end else begin
          s_sh = s_sh << 1;
        end
        miso_i = s_sh[blen-1];
      end
      if (!p_cs && cs_n_o) begin
        if (lag_exact) check(cyc - t_fall == CS_LAG + 1, "R3 CS lag", cyc - t_fall, CS_LAG + 1);
        else check(cyc - t_fall >= CS_LAG + 1, "R3 CS lag minimum", cyc - t_fall, CS_LAG + 1);
      end
    end
    p_cs = cs_n_o;
    p_sclk = sclk_o;
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_len(input int v, input bit exp9);
    @(negedge clk); cfg_we_i = 1'b1; cfg_len_i = 4'(v);
    @(negedge clk); cfg_we_i = 1'b0;
    #1 check(word_len9_o == exp9, "R4 word length select", int'(word_len9_o), int'(exp9));
    blen = exp9 ? 9 : 8;
    bmask = mask_of(exp9);
  endtask

  task automatic push_words(input int n, input int accept);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tx_push_i = 1'b1;
      tx_data_i = 9'($urandom);
      if (i < accept) exp_tx.push_back(tx_data_i);
    end
    @(negedge clk); tx_push_i = 1'b0;
  endtask

  task automatic pulse_active();
    @(negedge clk); active_i = 1'b1;
    @(negedge clk); active_i = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int k = 0;
    while (!done_o && k < 8000) begin @(negedge clk); k++; end
    check(done_o == 1'b1, tag, int'(done_o), 1);
  endtask

  task automatic pop_one();
    @(negedge clk);
    if (exp_rx.size() == 0) check(1'b0, "R6 receive queue model empty", 0, 1);
    else begin
      logic [8:0] e;
      e = exp_rx.pop_front();
      check(rx_data_o == e, "R6 received word", int'(rx_data_o), int'(e));
    end
    rx_pop_i = 1'b1;
    @(negedge clk); rx_pop_i = 1'b0;
  endtask

  task automatic drain_rx();
    int k = 0;
    @(negedge clk);
    while (!rx_empty_o && k < 64) begin pop_one(); k++; end
    check(exp_rx.size() == 0, "R6 receive word count", exp_rx.size(), 0);
  endtask

  task automatic run_txn(input int nw, input bit l9, input int h);
    set_len(l9 ? 9 : 8, l9);
    div_i = DIV_W'(h); half = (h == 0) ? 1 : h;
    lead_exact = 1'b1; lag_exact = 1'b1;
    push_words(nw, nw);
    pulse_active();
    wait_done("R11 random transaction done");
    check(exp_tx.size() == 0, "R5 all words shifted", exp_tx.size(), 0);
    #1 check(irq_o == 1'b1, "R8 irq from done", int'(irq_o), 1);
    drain_rx();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog R1..: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int r0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; active_i = 1'b0; cfg_we_i = 1'b0; cfg_len_i = 4'd8;
    div_i = DIV_W'(1); tx_push_i = 1'b0; tx_data_i = '0; rx_pop_i = 1'b0;
    tick(3);
    #1;
    check(cs_n_o == 1'b1, "R1 reset cs_n", int'(cs_n_o), 1);
    check(sclk_o == 1'b0 && mosi_o == 1'b0, "R1 reset sclk/mosi", int'({sclk_o, mosi_o}), 0);
    check(irq_o == 1'b0 && done_o == 1'b0, "R1 reset irq/done", int'({irq_o, done_o}), 0);
    check(tx_empty_o && rx_empty_o, "R1 reset FIFOs empty", int'({tx_empty_o, rx_empty_o}), 3);
    check(word_len9_o == 1'b0, "R1 reset word length", int'(word_len9_o), 0);
    @(negedge clk); rst_n = 1'b1;

    // R4: only 8 and 9 are accepted
    set_len(12, 1'b0);
    set_len(9, 1'b1);
    set_len(3, 1'b1);
    set_len(0, 1'b1);
    set_len(8, 1'b0);

    // R8 start request, R10 idle wait with CS low
    div_i = DIV_W'(2); half = 2; lead_exact = 1'b0; lag_exact = 1'b0;
    @(negedge clk); active_i = 1'b1;
    #1 check(irq_o == 1'b1, "R8 irq on start with empty FIFO", int'(irq_o), 1);
    r0 = n_rise;
    tick(30);
    check(cs_n_o == 1'b0, "R10 CS held low while waiting", int'(cs_n_o), 0);
    check(n_rise == r0, "R10 SCLK idle while FIFO empty", n_rise - r0, 0);
    push_words(3, 3);
    tick(120);
    check(exp_tx.size() == 0, "R10 shifting resumed after push", exp_tx.size(), 0);
    check(cs_n_o == 1'b0, "R10 CS still low while active", int'(cs_n_o), 0);
    @(negedge clk); active_i = 1'b0;
    wait_done("R11 done after active cleared");
    drain_rx();

    // R8 threshold: more than half full, nothing received yet
    set_len(9, 1'b1);
    div_i = DIV_W'(1); half = 1; lead_exact = 1'b1; lag_exact = 1'b0;
    push_words(10, 10);
    #1 check(irq_o == 1'b1, "R8 irq held by done while idle", int'(irq_o), 1);
    @(negedge clk); active_i = 1'b1;
    tick(2);
    #1 check(done_o == 1'b0, "R11 done cleared on new start", int'(done_o), 0);
    check(irq_o == 1'b0, "R8 no irq above half full", int'(irq_o), 0);
    while (!tx_empty_o) @(negedge clk);
    #1 check(irq_o == 1'b1, "R8 irq when FIFO low", int'(irq_o), 1);
    @(negedge clk); active_i = 1'b0;
    wait_done("R11 threshold transaction done");
    drain_rx();

    // R9 full FIFO and dropped push, leaves receive FIFO full
    set_len(8, 1'b0);
    div_i = DIV_W'(1); half = 1; lead_exact = 1'b1; lag_exact = 1'b1;
    push_words(17, 16);
    #1 check(tx_full_o == 1'b1, "R9 tx full after 16 pushes", int'(tx_full_o), 1);
    pulse_active();
    wait_done("R11 full-FIFO transaction done");
    check(exp_tx.size() == 0, "R9 sixteen words sent", exp_tx.size(), 0);
    #1 check(rx_full_o == 1'b1, "R9 rx full after 16 words", int'(rx_full_o), 1);

    // R12 stall on full receive FIFO
    lead_exact = 1'b0;
    push_words(1, 1);
    r0 = n_rise;
    pulse_active();
    tick(40);
    check(n_rise == r0, "R12 no SCLK while rx full", n_rise - r0, 0);
    check(cs_n_o == 1'b0, "R12 CS low during stall", int'(cs_n_o), 0);
    pop_one();
    wait_done("R12 word completes after pop");
    drain_rx();

    // Constrained random transactions
    for (int t = 0; t < 10; t++) begin
      run_txn(1 + int'($urandom % 12), 1'($urandom), int'($urandom % 5));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule